// File: doc/BRIEF.md
# Two-Qubit Controlled-NOT Joint-State Expander

This block accepts a control qubit and a target qubit. Each arrives as a pair of complex fixed-point amplitudes, one for the zero basis state and one for the one basis state. The block applies a controlled-NOT and returns the joint two-qubit state as four complex amplitudes, one for each of the basis states |00>, |01>, |10> and |11>.

Once the two inputs have interacted they can no longer be held as two separate qubits, so the output is always the full four-amplitude vector. Each joint amplitude is the complex product of one control amplitude and one target amplitude. For the half where the control is one, the target's two amplitudes are crossed over.

The result lands in a clocked state register, so gate stages can be chained as a pipeline. The block takes one new pair of qubits every cycle and returns each result a fixed two cycles later.

Top module: `cnot_joint_state`

## Requirements
- R1: Every real value is a W = FRAC_W+2 bit two's-complement number with a sign bit, one integer bit and FRAC_W fraction bits, so 1.0 is 2^FRAC_W. Each complex port packs the real part in the upper W bits and the imaginary part in the lower W bits.
- R2: amp_00 equals ctl_a times tgt_a, and amp_01 equals ctl_a times tgt_b.
- R3: amp_10 equals ctl_b times tgt_b, and amp_11 equals ctl_b times tgt_a. These are the target amplitudes crossed over.
- R4: Each complex product uses real = xr*yr - xi*yi and imaginary = xr*yi + xi*yr. Both parts are formed at full precision and rounded only once.
- R5: Rounding goes to the nearest multiple of 2^-FRAC_W. An exact half rounds toward positive infinity, so +1.5 LSB gives 2 and -1.5 LSB gives -1.
- R6: A rounded part above the largest code saturates to 2^(W-1)-1. One below the smallest code saturates to -2^(W-1).
- R7: out_valid is high exactly two cycles after a cycle with in_valid high, and at no other time.
- R8: A new input can be accepted every cycle. Back-to-back inputs produce back-to-back results, in input order.
- R9: A control of exactly |0> (ctl_a = 1.0, ctl_b = 0) yields amp_10 and amp_11 of exactly zero. A control of exactly |1> yields amp_00 and amp_01 of exactly zero.
- R10: A synchronous reset clears out_valid and all four amplitudes to zero, and discards any input still in flight.
- R11: When no result arrives in a cycle, the amplitude outputs hold their previous values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input qubits present this cycle |
| ctl_a | input | 2W | Control amplitude of the zero state {re, im} |
| ctl_b | input | 2W | Control amplitude of the one state {re, im} |
| tgt_a | input | 2W | Target amplitude of the zero state {re, im} |
| tgt_b | input | 2W | Target amplitude of the one state {re, im} |
| out_valid | output | 1 | Joint state valid |
| amp_00 | output | 2W | Joint amplitude of the |00> state {re, im} |
| amp_01 | output | 2W | Joint amplitude of the |01> state {re, im} |
| amp_10 | output | 2W | Joint amplitude of the |10> state {re, im} |
| amp_11 | output | 2W | Joint amplitude of the |11> state {re, im} |

## Verification
The hardest cases to reach are the edges of the arithmetic. Normalised qubits never overflow and rarely land on an exact rounding tie. The stimulus therefore drives unnormalised extreme codes such as -2.0 times -2.0 to force saturation in both directions. It also uses products that fall exactly on half an LSB, to pin down the direction of a tie. Reset is asserted while a result is still inside the pipeline, to show that the in-flight result never appears.

// File: rtl/cnot_joint_state.sv
module cnot_joint_state #(
  parameter int FRAC_W = 8
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      in_valid,
  input  logic [2*(FRAC_W+2)-1:0]   ctl_a,
  input  logic [2*(FRAC_W+2)-1:0]   ctl_b,
  input  logic [2*(FRAC_W+2)-1:0]   tgt_a,
  input  logic [2*(FRAC_W+2)-1:0]   tgt_b,
  output logic                      out_valid,
  output logic [2*(FRAC_W+2)-1:0]   amp_00,
  output logic [2*(FRAC_W+2)-1:0]   amp_01,
  output logic [2*(FRAC_W+2)-1:0]   amp_10,
  output logic [2*(FRAC_W+2)-1:0]   amp_11
);
  localparam int W  = FRAC_W + 2;
  localparam int PW = 2*W + 1;
  localparam logic signed [PW-1:0] HALF = PW'(1) << (FRAC_W-1);
  localparam logic signed [PW-1:0] MAXV = PW'((1 << (W-1)) - 1);
  localparam logic signed [PW-1:0] MINV = -MAXV - PW'(1);

  function automatic logic [W-1:0] rnd_sat(input logic signed [PW-1:0] s);
    logic signed [PW-1:0] r;
    r = (s + HALF) >>> FRAC_W;
    if (r > MAXV)      return MAXV[W-1:0];
    else if (r < MINV) return MINV[W-1:0];
    else               return r[W-1:0];
  endfunction

  logic [2*W-1:0] op_x [4];
  logic [2*W-1:0] op_y [4];
  assign op_x[0] = ctl_a; assign op_y[0] = tgt_a;
  assign op_x[1] = ctl_a; assign op_y[1] = tgt_b;
  assign op_x[2] = ctl_b; assign op_y[2] = tgt_b;
  assign op_x[3] = ctl_b; assign op_y[3] = tgt_a;

  logic                  v1;
  logic signed [PW-1:0]  p_rr [4];
  logic signed [PW-1:0]  p_ii [4];
  logic signed [PW-1:0]  p_ri [4];
  logic signed [PW-1:0]  p_ir [4];
  logic [W-1:0]          st_re [4];
  logic [W-1:0]          st_im [4];

  always_ff @(posedge clk) begin
    if (rst) begin
      v1        <= 1'b0;
      out_valid <= 1'b0;
    end else begin
      v1        <= in_valid;
      out_valid <= v1;
    end
  end

  for (genvar k = 0; k < 4; k++) begin : g_prod
    logic signed [W-1:0] xr, xi, yr, yi;
    assign xr = op_x[k][2*W-1:W];
    assign xi = op_x[k][W-1:0];
    assign yr = op_y[k][2*W-1:W];
    assign yi = op_y[k][W-1:0];

    always_ff @(posedge clk) begin
      if (rst) begin
        p_rr[k] <= '0; p_ii[k] <= '0; p_ri[k] <= '0; p_ir[k] <= '0;
      end else if (in_valid) begin
        p_rr[k] <= PW'(xr) * PW'(yr);
        p_ii[k] <= PW'(xi) * PW'(yi);
        p_ri[k] <= PW'(xr) * PW'(yi);
        p_ir[k] <= PW'(xi) * PW'(yr);
      end
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        st_re[k] <= '0;
        st_im[k] <= '0;
      end else if (v1) begin
        st_re[k] <= rnd_sat(p_rr[k] - p_ii[k]);
        st_im[k] <= rnd_sat(p_ri[k] + p_ir[k]);
      end
    end
  end

  assign amp_00 = {st_re[0], st_im[0]};
  assign amp_01 = {st_re[1], st_im[1]};
  assign amp_10 = {st_re[2], st_im[2]};
  assign amp_11 = {st_re[3], st_im[3]};

  localparam logic [2*W-1:0] C_ONE = {W'(1 << FRAC_W), W'(0)};

  AST_LAT_TWO: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> ##1 out_valid); // R7
  AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !$past(rst) && !$past(rst, 2)) |-> $past(in_valid, 2)); // R7
  AST_RST_CLEAR: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!out_valid && amp_00 == '0 && amp_01 == '0 && amp_10 == '0 && amp_11 == '0)); // R10
  AST_CTRL_ZERO_PAIR: assert property (@(posedge clk) disable iff (rst)
    (in_valid && ctl_a == C_ONE && ctl_b == '0) |=> ##1 (amp_10 == '0 && amp_11 == '0)); // R9
  AST_CTRL_ONE_PAIR: assert property (@(posedge clk) disable iff (rst)
    (in_valid && ctl_b == C_ONE && ctl_a == '0) |=> ##1 (amp_00 == '0 && amp_01 == '0)); // R9
  AST_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(v1)) |-> ($stable(amp_00) && $stable(amp_01) && $stable(amp_10) && $stable(amp_11))); // R11
endmodule

// File: tb/tb_cnot_joint_state.sv
module tb_cnot_joint_state;
  localparam int F = 8;
  localparam int W = F + 2;
  localparam int CW = 2*W;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic [CW-1:0] ctl_a = '0, ctl_b = '0, tgt_a = '0, tgt_b = '0;
  logic out_valid;
  logic [CW-1:0] amp_00, amp_01, amp_10, amp_11;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  cnot_joint_state #(.FRAC_W(F)) dut (
    .clk(clk), .rst(rst), .in_valid(in_valid),
    .ctl_a(ctl_a), .ctl_b(ctl_b), .tgt_a(tgt_a), .tgt_b(tgt_b),
    .out_valid(out_valid), .amp_00(amp_00), .amp_01(amp_01),
    .amp_10(amp_10), .amp_11(amp_11)
  );

  function automatic logic [CW-1:0] cx(input int re, input int im);
    logic [W-1:0] r, i;
    r = W'(re);
    i = W'(im);
    return {r, i};
  endfunction

  function automatic int rs(input int v);
    int r;
    r = (v + (1 << (F-1))) >>> F;
    if (r > (1 << (W-1)) - 1) r = (1 << (W-1)) - 1;
    if (r < -(1 << (W-1))) r = -(1 << (W-1));
    return r;
  endfunction

  function automatic logic [CW-1:0] ref_mul(input logic [CW-1:0] a, input logic [CW-1:0] b);
    int ar, ai, br, bi;
    ar = int'($signed(a[CW-1:W])); ai = int'($signed(a[W-1:0]));
    br = int'($signed(b[CW-1:W])); bi = int'($signed(b[W-1:0]));
    return cx(rs(ar*br - ai*bi), rs(ar*bi + ai*br));
  endfunction

  task automatic chk(input string what, input logic [CW-1:0] got, input logic [CW-1:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", what, got, exp);
    end
  endtask

  task automatic drive(input logic [CW-1:0] ca, cb, ta, tb);
    ctl_a = ca; ctl_b = cb; tgt_a = ta; tgt_b = tb; in_valid = 1'b1;
  endtask

  task automatic run_one(input logic [CW-1:0] ca, cb, ta, tb, input string tag);
    @(negedge clk); drive(ca, cb, ta, tb);
    @(negedge clk); in_valid = 1'b0;
    chk({tag, " R7 valid not after one cycle"}, CW'(out_valid), CW'(0));
    @(negedge clk);
    chk({tag, " R7 valid after two cycles"}, CW'(out_valid), CW'(1));
    chk({tag, " R2 amp_00"}, amp_00, ref_mul(ca, ta));
    chk({tag, " R2 amp_01"}, amp_01, ref_mul(ca, tb));
    chk({tag, " R3 amp_10"}, amp_10, ref_mul(cb, tb));
    chk({tag, " R3 amp_11"}, amp_11, ref_mul(cb, ta));
    @(negedge clk);
    chk({tag, " R7 valid single cycle"}, CW'(out_valid), CW'(0));
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R10 reset valid", CW'(out_valid), CW'(0));
    chk("R10 reset amp_00", amp_00, '0);
    chk("R10 reset amp_11", amp_11, '0);
  endtask

  task automatic t_ctrl_zero();
    run_one(cx(256, 0), cx(0, 0), cx(100, -37), cx(-5, 200), "ctrl0");
    chk("R9 ctrl0 amp_10 zero", amp_10, '0);
    chk("R9 ctrl0 amp_11 zero", amp_11, '0);
    chk("R1 ctrl0 amp_00 = target a", amp_00, cx(100, -37));
  endtask

  task automatic t_ctrl_one();
    run_one(cx(0, 0), cx(256, 0), cx(60, 70), cx(-90, 11), "ctrl1");
    chk("R3 ctrl1 amp_10 = target b", amp_10, cx(-90, 11));
    chk("R3 ctrl1 amp_11 = target a", amp_11, cx(60, 70));
    chk("R9 ctrl1 amp_00 zero", amp_00, '0);
    chk("R9 ctrl1 amp_01 zero", amp_01, '0);
  endtask

  task automatic t_superpos();
    run_one(cx(181, 0), cx(0, 181), cx(181, 0), cx(-128, 128), "superpos");
  endtask

  task automatic t_imag();
    run_one(cx(0, 256), cx(128, -64), cx(0, 256), cx(30, 40), "imag");
    chk("R4 i*i = -1", amp_00, cx(-256, 0));
  endtask

  task automatic t_round();
    run_one(cx(3, 0), cx(0, 0), cx(128, 0), cx(-128, 0), "round");
    chk("R5 +1.5 LSB rounds to 2", amp_00, cx(2, 0));
    chk("R5 -1.5 LSB rounds to -1", amp_01, cx(-1, 0));
  endtask

  task automatic t_sat();
    run_one(cx(-512, 0), cx(-512, -512), cx(-512, 0), cx(511, 0), "sat");
    chk("R6 positive saturation", amp_00, cx(511, 0));
    chk("R6 negative saturation", amp_01, cx(-512, 0));
  endtask

  task automatic t_hold();
    logic [CW-1:0] h0, h3;
    h0 = amp_00; h3 = amp_11;
    @(negedge clk); tgt_a = cx(7, 7); ctl_a = cx(9, 9);
    @(negedge clk); @(negedge clk);
    chk("R11 amp_00 held", amp_00, h0);
    chk("R11 amp_11 held", amp_11, h3);
  endtask

  task automatic t_pipeline();
    logic [CW-1:0] ca [3], cb [3], ta [3], tb [3];
    ca[0] = cx(181, 0);  cb[0] = cx(181, 0);  ta[0] = cx(256, 0); tb[0] = cx(0, 0);
    ca[1] = cx(0, 100);  cb[1] = cx(200, 9);  ta[1] = cx(-50, 3); tb[1] = cx(77, -77);
    ca[2] = cx(256, 0);  cb[2] = cx(0, 0);    ta[2] = cx(12, 34); tb[2] = cx(56, 78);
    for (int cyc = 0; cyc < 6; cyc++) begin
      @(negedge clk);
      if (cyc >= 2 && cyc < 5) begin
        chk("R8 back-to-back valid", CW'(out_valid), CW'(1));
        chk("R8 amp_00 in order", amp_00, ref_mul(ca[cyc-2], ta[cyc-2]));
        chk("R8 amp_01 in order", amp_01, ref_mul(ca[cyc-2], tb[cyc-2]));
        chk("R8 amp_10 in order", amp_10, ref_mul(cb[cyc-2], tb[cyc-2]));
        chk("R8 amp_11 in order", amp_11, ref_mul(cb[cyc-2], ta[cyc-2]));
      end
      if (cyc == 5) chk("R7 valid drops after burst", CW'(out_valid), CW'(0));
      if (cyc < 3) drive(ca[cyc], cb[cyc], ta[cyc], tb[cyc]);
      else in_valid = 1'b0;
    end
  endtask

  task automatic t_flush();
    @(negedge clk); drive(cx(200, 0), cx(100, 0), cx(200, 0), cx(150, 0));
    @(negedge clk); in_valid = 1'b0; rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    chk("R10 flush amp_00 cleared", amp_00, '0);
    @(negedge clk);
    chk("R10 flushed result never appears", CW'(out_valid), CW'(0));
    @(negedge clk);
    chk("R10 still no valid", CW'(out_valid), CW'(0));
    chk("R10 amp_10 cleared", amp_10, '0);
  endtask

  initial begin
    #(20 * 100000);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_ctrl_zero();
    t_ctrl_one();
    t_superpos();
    t_imag();
    t_round();
    t_sat();
    t_hold();
    t_pipeline();
    t_flush();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule